// File: doc/BRIEF.md
# Counting-Ramp Conversion Controller

This block is the digital side of a counter-type feedback analog-to-digital converter. A binary up-counter drives the input bus of an external DAC directly. An external comparator returns a single bit that is 1 while the analog input is still above the DAC output. While the conversion control input is high and the comparator reports 1, the code climbs by one per clock. Once the comparator drops to 0, the code stops at the first value that reaches the input.

The running count must not be used as the result, because it changes throughout a conversion. A separate result register therefore captures the count on the falling edge of the conversion control. That register is the only value that downstream logic reads. A one-cycle valid pulse marks each new result. The rising edge of the conversion control clears the counter, so every conversion ramps up from zero.

The comparator and the DAC are analog parts and are not part of this block. The counter width is a parameter; its default is 8 bits.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While rst_ni is low, dac_code_o and result_o are all zeros and valid_o is 0.
- R2: In any clock edge at which conv_i is sampled low, dac_code_o keeps its value.
- R3: dac_code_o is the live counter value. At the edge where conv_i is first sampled high after being low, it becomes all zeros, whatever cmp_i is.
- R4: At each later edge with conv_i high and cmp_i = 1, dac_code_o increases by exactly one. A constant input level V therefore yields a final code of min(V, all-ones).
- R5: The counter saturates. At all-ones with cmp_i = 1 it stays at all-ones and never wraps to zero.
- R6: result_o changes only at the edge where conv_i is sampled low after being high. At that edge it takes the dac_code_o value present before the edge. At every other edge, including those during a conversion, it holds.
- R7: valid_o is 1 for exactly one cycle, starting with the same edge that loads result_o, and 0 otherwise.
- R8: Within one conversion, once cmp_i is sampled 0 with conv_i high, the count freezes. It stays frozen until conv_i falls, even if cmp_i returns to 1.
- R9: A new rising edge of conv_i clears both the count and the freeze from the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Conversion control; high enables ramping, falling edge captures the result |
| cmp_i | input | 1 | Comparator: 1 while the analog input is above the DAC output |
| dac_code_o | output | CODE_W | Live counter value driving the DAC |
| result_o | output | CODE_W | Captured conversion result |
| valid_o | output | 1 | One-cycle pulse after result_o loads |

## Verification
A wrong count appears on dac_code_o in the very next cycle, because the counter drives that port without any intermediate stage. A freeze flag that is stuck or lost shows up only when the comparator toggles in the middle of a conversion. The bench therefore forces such a pattern and compares the code at every clock. A wrong edge detector or capture path appears one cycle after conv_i falls, either as a stale result_o or as a valid_o pulse that is missing or lasts two cycles.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } conv_evt_t;
endpackage

// File: rtl/conv_edge_det.sv
module conv_edge_det
  import ramp_adc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      conv_i,
  output conv_evt_t evt_o
);
  logic conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= conv_i;
  end

  assign evt_o.rise = conv_i & ~conv_q;
  assign evt_o.fall = ~conv_i & conv_q;
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] count_o
);
  localparam logic [CODE_W-1:0] MaxCode = {CODE_W{1'b1}};

  logic [CODE_W-1:0] cnt_q;
  logic              frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (run_i && !frozen_q) begin
      if (!cmp_i)                frozen_q <= 1'b1;
      else if (cnt_q != MaxCode) cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] result_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) result_o <= data_i;
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] result_o,
  output logic              valid_o
);
  conv_evt_t         evt;
  logic [CODE_W-1:0] count;

  conv_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .conv_i (conv_i),
    .evt_o  (evt)
  );

  ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (evt.rise),
    .run_i   (conv_i),
    .cmp_i   (cmp_i),
    .count_o (count)
  );

  result_hold #(.CODE_W(CODE_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (evt.fall),
    .data_i   (count),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  assign dac_code_o = count;
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_i,
  input logic              cmp_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [CODE_W-1:0] result_o,
  input logic              valid_o
);
  logic conv_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_d <= 1'b0;
    else         conv_d <= conv_i;
  end

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (dac_code_o == '0 && result_o == '0 && !valid_o);
    end
  end

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_i |=> $stable(dac_code_o));

  a_r9_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !conv_d) |=> dac_code_o == '0);

  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && conv_d) |=> (dac_code_o == $past(dac_code_o) ||
                            dac_code_o == CODE_W'($past(dac_code_o) + 1'b1)));

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o == '1 && !(conv_i && !conv_d)) |=> dac_code_o == '1);

  a_r6_result_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!conv_i && conv_d) |=> $stable(result_o));

  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_i && conv_d) |=> (valid_o && result_o == $past(dac_code_o)));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .conv_i     (conv_i),
  .cmp_i      (cmp_i),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .valid_o    (valid_o)
);

// File: tb/tb_ramp_adc_ctrl.sv
module tb_ramp_adc_ctrl;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv = 1'b0;
  logic         cmp;
  logic [W-1:0] dac_code, result;
  logic         valid;

  int  vin = 0;
  bit  force_en = 1'b0;
  bit  force_val = 1'b0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  // behavioural comparator on the DAC output
  assign cmp = force_en ? force_val : (vin > int'(dac_code));

  ramp_adc_ctrl #(.CODE_W(W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .conv_i     (conv),
    .cmp_i      (cmp),
    .dac_code_o (dac_code),
    .result_o   (result),
    .valid_o    (valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int  m_cnt, m_res;
  bit  m_stop, m_prev, m_valid;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_res = 0; m_stop = 0; m_prev = 0; m_valid = 0;
    end else begin
      m_valid = m_prev && !conv;
      if (m_valid) m_res = m_cnt;
      if (conv && !m_prev) begin
        m_cnt = 0; m_stop = 0;
      end else if (conv && !m_stop) begin
        if (!cmp) m_stop = 1;
        else if (m_cnt < MAX) m_cnt++;
      end
      m_prev = conv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(dac_code) == m_cnt, "R3/R4 code", int'(dac_code), m_cnt);
      check(int'(result) == m_res, "R6 result", int'(result), m_res);
      check(valid == m_valid, "R7 valid", int'(valid), int'(m_valid));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic convert(input int level, input int len);
    vin = level;
    conv = 1'b1;
    cycles(len);
    conv = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cycles(3);
    check(dac_code == '0 && result == '0 && !valid, "R1 reset", int'(dac_code), 0);
    rst_n = 1'b1;
    cycles(2);

    // R4: plain ramp
    convert(37, 300);
    check(int'(result) == 37, "R4 final code", int'(result), 37);
    check(valid == 1'b1, "R7 valid rise", int'(valid), 1);
    @(negedge clk);
    check(valid == 1'b0, "R7 valid one cycle", int'(valid), 0);
    cycles(3);

    convert(0, 20);
    check(int'(result) == 0, "R4 zero input", int'(result), 0);
    cycles(3);

    // R5: saturation
    convert(300, 300);
    check(int'(result) == MAX, "R5 saturate", int'(result), MAX);
    cycles(10);
    check(int'(dac_code) == MAX, "R2 hold while idle", int'(dac_code), MAX);

    // R9 and R6: restart clears, result held mid conversion
    vin = 100;
    conv = 1'b1;
    @(negedge clk);
    check(int'(dac_code) == 0, "R9 clear on start", int'(dac_code), 0);
    cycles(20);
    check(int'(result) == MAX, "R6 result held", int'(result), MAX);
    check(int'(dac_code) == 20, "R4 one per clock", int'(dac_code), 20);
    cycles(150);
    conv = 1'b0;
    @(negedge clk);
    check(int'(result) == 100, "R4 mid level", int'(result), 100);
    cycles(3);

    // R8: freeze despite comparator returning to 1
    force_en = 1'b1; force_val = 1'b1;
    conv = 1'b1;
    cycles(6);
    force_val = 1'b0;
    @(negedge clk);
    force_val = 1'b1;
    cycles(10);
    check(int'(dac_code) == 5, "R8 frozen", int'(dac_code), 5);
    conv = 1'b0;
    @(negedge clk);
    check(int'(result) == 5, "R8 result", int'(result), 5);
    force_en = 1'b0;
    cycles(3);

    // R9: new conversion forgets the freeze
    convert(60, 100);
    check(int'(result) == 60, "R9 freeze cleared", int'(result), 60);
    cycles(2);

    // one-cycle conversion captures the cleared count
    convert(100, 1);
    check(int'(result) == 0, "R6 short pulse", int'(result), 0);
    cycles(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule